// File: doc/BRIEF.md
# Dual-Modulus Prescaler Feedback Divider

This block divides a fast clock by any programmed integer N in a PLL feedback path. Only a small prescaler runs at the full input rate. It divides by 8 or by 9. Two slower counters choose which ratio the prescaler uses in each of its cycles.

- The main counter counts prescaler cycles up to M = N div 8.
- The swallow counter selects divide-by-9 for the first A = N mod 8 of those cycles.

The total is M·8 + A = N input cycles per output period, so every integer from 56 to 4095 can be reached.

The divider has two outputs.

- A one-cycle pulse at each period boundary, for a phase-frequency detector.
- A near-square clock that is high for the first half of the main count.

A new modulus is written with a load strobe. It is held until the current period ends, so no period is ever cut short or stretched. A modulus below 56 is refused: an error flag is raised and the divider keeps running on its previous setting.

Top module: `dmpd_feedback_divider`

## Requirements
- R1: The interval between successive rising cycles of `pulse_o` is exactly N input clock cycles, for every N from 56 to 4095.
- R2: `pulse_o` is high for exactly one input clock cycle per period.
- R3: While `rst` is high, `pulse_o` and `err_o` are low and the modulus returns to `RESET_MOD` (100 by default). The first pulse after release appears in the N-th cycle, counting the first cycle with `rst` low as cycle 1.
- R4: A valid modulus loaded with `load` takes effect at the next period boundary. A load sampled in the same cycle as the pulse governs the very next period. If several loads arrive within one period, the last one wins. A period already in progress is never altered.
- R5: A load with `mod_in` below 56 (including 0) sets `err_o` in the next cycle and leaves the running modulus and any pending modulus unchanged.
- R6: A load with `mod_in` of 56 or more clears `err_o` in the next cycle.
- R7: `div_clk_o` is high for the first h = ceil(M/2) prescaler cycles of each period, where M = N div 8 and A = N mod 8. That is h·8 + min(A, h) input cycles high per period, starting in the cycle after the pulse.
- R8: In each period the prescaler divides by 9 for exactly the first A of its M cycles and by 8 for the rest. All swallow cycles are used up by the period boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_vco | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Strobe that captures `mod_in` |
| mod_in | input | 12 | Requested overall modulus N |
| pulse_o | output | 1 | One-cycle pulse at each period boundary |
| div_clk_o | output | 1 | Divided clock, roughly 50 % duty |
| err_o | output | 1 | Set by a refused (too small) modulus |

## Verification
A fault in the prescaler's ratio selection or in the swallow count shifts the very next pulse interval by one or more cycles. The period scoreboard therefore reports it within one output period. A wrong main-count limit or a wrong half-count also shows in the first affected period, either in the pulse interval or in the number of cycles `div_clk_o` is high. A fault in the pending-modulus logic makes a period use the wrong N right at the boundary where the change should occur. The sweep covers every N from 56 to 127, modulus changes that land exactly on the pulse cycle, and the largest moduli. Together these cover every swallow value and the smallest main counts, where the M ≥ A limit is tightest.

// File: rtl/dmpd_pkg.sv
package dmpd_pkg;

   // Ratio selection for the fast prescaler
   typedef enum logic {
      PS_BASE    = 1'b0,   // divide by P
      PS_SWALLOW = 1'b1    // divide by P+1
   } ps_mode_e;

   // Smallest modulus for which the main count is never below the swallow count
   function automatic int unsigned min_modulus(input int unsigned p);
      return p * (p - 1);
   endfunction

endpackage

// File: rtl/dmpd_prescaler.sv
module dmpd_prescaler
   import dmpd_pkg::*;
#(
   parameter int unsigned P_LOG2 = 3
) (
   input  logic     clk,
   input  logic     rst,
   input  ps_mode_e mode,
   output logic     tick
);

   localparam int unsigned P  = 1 << P_LOG2;
   localparam int unsigned CW = P_LOG2 + 1;

   logic [CW-1:0] cnt;
   logic [CW-1:0] lim;

   always_comb begin
      if (mode == PS_SWALLOW) lim = CW'(P);
      else                    lim = CW'(P - 1);
   end

   assign tick = (cnt == lim);

   always_ff @(posedge clk) begin
      if (rst)       cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + CW'(1);
   end

   // R8: the ratio request may only change when a prescaler cycle closes
   a_r8_mode_steady: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(mode));

   // R8: the count never runs beyond the longer ratio
   a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
      cnt <= CW'(P));

endmodule

// File: rtl/dmpd_period_ctr.sv
module dmpd_period_ctr
   import dmpd_pkg::*;
#(
   parameter int unsigned P_LOG2     = 3,
   parameter int unsigned MAIN_W     = 9,
   parameter int unsigned RESET_SWAL = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tick,
   input  logic [MAIN_W-1:0] act_last,
   input  logic [MAIN_W-1:0] act_half,
   input  logic [P_LOG2-1:0] nxt_swal,
   output ps_mode_e          mode,
   output logic              boundary,
   output logic              div_clk
);

   logic [MAIN_W-1:0] main_k;
   logic [P_LOG2-1:0] swal_cnt;

   assign mode     = (swal_cnt != '0) ? PS_SWALLOW : PS_BASE;
   assign boundary = tick && (main_k == act_last);
   assign div_clk  = (main_k < act_half);

   always_ff @(posedge clk) begin
      if (rst) begin
         main_k   <= '0;
         swal_cnt <= P_LOG2'(RESET_SWAL);
      end else if (boundary) begin
         main_k   <= '0;
         swal_cnt <= nxt_swal;
      end else if (tick) begin
         main_k <= main_k + MAIN_W'(1);
         if (swal_cnt != '0) swal_cnt <= swal_cnt - P_LOG2'(1);
      end
   end

   // R8: every swallow cycle is spent by the time the period closes
   a_r8_swallow_spent: assert property (@(posedge clk) disable iff (rst)
      boundary |-> (swal_cnt <= P_LOG2'(1)));

   // R2: the boundary pulse is never two cycles wide
   a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
      boundary |=> !boundary);

   // R1: the main count stays within the running limit
   a_r1_main_bound: assert property (@(posedge clk) disable iff (rst)
      main_k <= act_last);

endmodule

// File: rtl/dmpd_modulus_reg.sv
module dmpd_modulus_reg
   import dmpd_pkg::*;
#(
   parameter int unsigned P_LOG2    = 3,
   parameter int unsigned MAIN_W    = 9,
   parameter int unsigned RESET_MOD = 100
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  logic [MAIN_W+P_LOG2-1:0] mod_in,
   input  logic                     boundary,
   output logic [MAIN_W-1:0]        act_last,
   output logic [MAIN_W-1:0]        act_half,
   output logic [P_LOG2-1:0]        nxt_swal,
   output logic                     err_o
);

   localparam int unsigned P     = 1 << P_LOG2;
   localparam int unsigned N_W   = MAIN_W + P_LOG2;
   localparam int unsigned MIN_N = min_modulus(P);
   localparam logic [MAIN_W-1:0] RST_LAST = MAIN_W'(RESET_MOD / P - 1);
   localparam logic [MAIN_W-1:0] RST_HALF = MAIN_W'((RESET_MOD / P + 1) / 2);

   logic [N_W-1:0]  act_mod;
   logic [N_W-1:0]  pend_mod;
   logic            pend_v;
   logic            in_ok;
   logic            take;
   logic [N_W-1:0]  nxt_mod;
   logic [MAIN_W:0] nxt_m_ext;

   assign in_ok = (mod_in >= N_W'(MIN_N));
   assign take  = load && in_ok;

   always_comb begin
      if (take)        nxt_mod = mod_in;
      else if (pend_v) nxt_mod = pend_mod;
      else             nxt_mod = act_mod;
   end

   assign nxt_swal  = nxt_mod[P_LOG2-1:0];
   assign nxt_m_ext = {1'b0, nxt_mod[N_W-1:P_LOG2]};

   always_ff @(posedge clk) begin
      if (rst) begin
         act_mod  <= N_W'(RESET_MOD);
         act_last <= RST_LAST;
         act_half <= RST_HALF;
         pend_mod <= '0;
         pend_v   <= 1'b0;
         err_o    <= 1'b0;
      end else begin
         if (boundary) begin
            act_mod  <= nxt_mod;
            act_last <= nxt_mod[N_W-1:P_LOG2] - MAIN_W'(1);
            act_half <= MAIN_W'((nxt_m_ext + (MAIN_W+1)'(1)) >> 1);
            pend_v   <= 1'b0;
         end else if (take) begin
            pend_mod <= mod_in;
            pend_v   <= 1'b1;
         end
         if (load) err_o <= !in_ok;
      end
   end

   // R4: the running modulus changes only at a period boundary
   a_r4_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
      !boundary |=> $stable(act_mod));

   // R5: a refused load with nothing pending leaves the running modulus alone
   a_r5_reject_hold: assert property (@(posedge clk) disable iff (rst)
      (load && (mod_in < N_W'(MIN_N)) && !pend_v) |=> $stable(act_mod));

   // R1: the running modulus always lies in the supported range
   a_r1_act_range: assert property (@(posedge clk) disable iff (rst)
      act_mod >= N_W'(MIN_N));

endmodule

// File: rtl/dmpd_feedback_divider.sv
module dmpd_feedback_divider
   import dmpd_pkg::*;
#(
   parameter int unsigned P_LOG2    = 3,
   parameter int unsigned MAIN_W    = 9,
   parameter int unsigned RESET_MOD = 100
) (
   input  logic                     clk_vco,
   input  logic                     rst,
   input  logic                     load,
   input  logic [MAIN_W+P_LOG2-1:0] mod_in,
   output logic                     pulse_o,
   output logic                     div_clk_o,
   output logic                     err_o
);

   localparam int unsigned P     = 1 << P_LOG2;
   localparam int unsigned MIN_N = min_modulus(P);
   localparam int unsigned MAX_N = ((1 << MAIN_W) - 1) * P + (P - 1);

   // Elaboration-time parameter checks
   if (P_LOG2 < 1 || P_LOG2 > 6) begin : g_bad_plog2
      $error("P_LOG2 out of supported range");
   end
   if (((1 << MAIN_W) - 1) < (P - 1)) begin : g_bad_main_w
      $error("MAIN_W too small to cover the swallow range");
   end
   if (RESET_MOD < MIN_N || RESET_MOD > MAX_N) begin : g_bad_reset_mod
      $error("RESET_MOD outside the reachable modulus range");
   end

   ps_mode_e          mode;
   logic              tick;
   logic              boundary;
   logic [MAIN_W-1:0] act_last;
   logic [MAIN_W-1:0] act_half;
   logic [P_LOG2-1:0] nxt_swal;

   dmpd_prescaler #(.P_LOG2(P_LOG2)) u_presc (
      .clk  (clk_vco),
      .rst  (rst),
      .mode (mode),
      .tick (tick)
   );

   dmpd_period_ctr #(
      .P_LOG2    (P_LOG2),
      .MAIN_W    (MAIN_W),
      .RESET_SWAL(RESET_MOD % P)
   ) u_ctr (
      .clk      (clk_vco),
      .rst      (rst),
      .tick     (tick),
      .act_last (act_last),
      .act_half (act_half),
      .nxt_swal (nxt_swal),
      .mode     (mode),
      .boundary (boundary),
      .div_clk  (div_clk_o)
   );

   dmpd_modulus_reg #(
      .P_LOG2   (P_LOG2),
      .MAIN_W   (MAIN_W),
      .RESET_MOD(RESET_MOD)
   ) u_mod (
      .clk      (clk_vco),
      .rst      (rst),
      .load     (load),
      .mod_in   (mod_in),
      .boundary (boundary),
      .act_last (act_last),
      .act_half (act_half),
      .nxt_swal (nxt_swal),
      .err_o    (err_o)
   );

   assign pulse_o = boundary;

   // R5: a refused load raises the error flag one cycle later
   a_r5_flag_raise: assert property (@(posedge clk_vco) disable iff (rst)
      (load && (mod_in < (MAIN_W+P_LOG2)'(MIN_N))) |=> err_o);

   // R3: the divider output is quiet during the first cycle after release
   a_r3_quiet_after_reset: assert property (@(posedge clk_vco)
      rst |=> !pulse_o);

endmodule

// File: tb/dmpd_feedback_divider_bench.sv
module dmpd_feedback_divider_bench;
   localparam int CLK_PERIOD = 10;
   localparam int RESET_MOD  = 100;

   logic        clk    = 1'b0;
   logic        rst    = 1'b1;
   logic        load   = 1'b0;
   logic [11:0] mod_in = '0;
   logic        pulse_o, div_clk_o, err_o;

   always #(CLK_PERIOD / 2) clk = ~clk;

   dmpd_feedback_divider u_dmpd_feedback_divider (
      .clk_vco   (clk),
      .rst       (rst),
      .load      (load),
      .mod_in    (mod_in),
      .pulse_o   (pulse_o),
      .div_clk_o (div_clk_o),
      .err_o     (err_o)
   );

   int n_checks = 0;
   int n_fail   = 0;
   int exp_q[$];
   int pulses   = 0;
   int cyc      = 0;
   int hi       = 0;
   int cur      = RESET_MOD;
   bit prev_p   = 1'b0;
   bit first_p  = 1'b1;
   bit changed  = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_high(input int n);
      int m = n / 8;
      int a = n % 8;
      int h = (m + 1) / 2;
      return h * 8 + ((a < h) ? a : h);
   endfunction

   // Monitor: pops expected moduli at each boundary and checks intervals
   always @(negedge clk) begin
      if (rst) begin
         cyc = 0; hi = 0; cur = RESET_MOD; prev_p = 1'b0;
         first_p = 1'b1; changed = 1'b0;
         exp_q.delete();
      end else begin
         cyc++;
         if (div_clk_o) hi++;
         if (pulse_o) begin
            // R1 / R8 interval; R3 for the first period, R4 after a change
            check(cyc == cur, first_p ? "R3" : (changed ? "R4" : "R1/R8"), cyc, cur);
            check(!prev_p, "R2", int'(prev_p), 0);
            check(hi == exp_high(cur), "R7", hi, exp_high(cur));
            pulses++;
            first_p = 1'b0;
            changed = 1'b0;
            while (exp_q.size() > 0) begin
               cur = exp_q.pop_front();
               changed = 1'b1;
            end
            cyc = 0; hi = 0;
         end
         prev_p = pulse_o;
      end
   end

   // Driver: loads a modulus and queues it as expected when it is valid
   task automatic load_mod(input int n);
      @(posedge clk); #1;
      load   = 1'b1;
      mod_in = 12'(n);
      if (n >= 56) exp_q.push_back(n);
      @(posedge clk); #1;
      load = 1'b0;
   endtask

   task automatic wait_pulses(input int k);
      int s = pulses;
      wait (pulses >= s + k);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      check(pulse_o == 1'b0, "R3", int'(pulse_o), 0);
      check(err_o == 1'b0, "R3", int'(err_o), 0);
      @(posedge clk); #1;
      rst = 1'b0;
      wait_pulses(2);

      // Every modulus from the minimum up through all swallow values at small M
      for (int n = 56; n <= 127; n++) begin
         load_mod(n);
         wait_pulses(2);
      end

      // Refused moduli: flag set, running period unchanged (R5)
      load_mod(0);
      @(negedge clk);
      check(err_o == 1'b1, "R5", int'(err_o), 1);
      load_mod(55);
      @(negedge clk);
      check(err_o == 1'b1, "R5", int'(err_o), 1);
      wait_pulses(2);

      // Valid load clears the flag (R6)
      load_mod(200);
      @(negedge clk);
      check(err_o == 1'b0, "R6", int'(err_o), 0);
      wait_pulses(2);

      // Refused load while a valid one is pending keeps the pending value (R5)
      load_mod(96);
      load_mod(13);
      wait_pulses(2);

      // Large moduli
      load_mod(4095); wait_pulses(2);
      load_mod(4088); wait_pulses(2);
      load_mod(4087); wait_pulses(1);
      load_mod(2049); wait_pulses(2);
      load_mod(1000); wait_pulses(2);

      // Several loads in one period: the last wins (R4)
      load_mod(300);
      load_mod(77);
      wait_pulses(3);

      // Load sampled in the pulse cycle governs the next period (R4)
      @(negedge clk);
      while (!pulse_o) @(negedge clk);
      repeat (77 - 1) @(posedge clk);
      load_mod(150);
      wait_pulses(2);

      // Load one cycle after the pulse waits a full period (R4)
      @(negedge clk);
      while (!pulse_o) @(negedge clk);
      load_mod(63);
      wait_pulses(3);

      // Reset in mid-period returns to the default modulus (R3)
      repeat (20) @(posedge clk);
      #1 rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(pulse_o == 1'b0, "R3", int'(pulse_o), 0);
      check(err_o == 1'b0, "R3", int'(err_o), 0);
      @(posedge clk); #1;
      rst = 1'b0;
      wait_pulses(2);

      finish_run();
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 200000, 0);
      finish_run();
   end

endmodule